// File: doc/BRIEF.md
# Byte-Wide Memory DMA Engine

This engine copies a block of words between on-chip program or data memory and an external memory that is eight bits wide and divided into 256 pages of 16K bytes. A word is assembled from, or split into, a run of byte accesses. Software programs the engine through a small register port with these settings:

- the on-chip start address;
- the external page and offset;
- a 2-bit format code;
- the direction;
- a per-byte wait-state count.

Writing a nonzero word count starts the engine. It then drives the byte bus by itself. For each word it asks the on-chip memory for a single cycle through a request/grant handshake. When the count reaches zero it stops and pulses an interrupt.

The sequencer uses five states:

- IDLE waits for a start.
- FETCH requests an on-chip read. It is used only for stores.
- BYTE holds one external strobe for the programmed number of cycles.
- PUT requests an on-chip write. It is used only for loads.
- STEP closes one word.

The transitions are:

- IDLE→BYTE on start when loading.
- IDLE→FETCH on start when storing.
- FETCH→BYTE on grant.
- BYTE→BYTE between bytes of a word.
- BYTE→PUT after the last byte of a load.
- BYTE→STEP after the last byte of a store.
- PUT→STEP on grant.
- STEP→IDLE when the last word has been closed.
- STEP→BYTE or STEP→FETCH otherwise.

Top module: `bytemem_dma`

## Requirements
- R1: After reset every register reads back zero, the engine is idle, and no strobe, request, halt or interrupt is driven.
- R2: A register write with select 3 (count) carrying a nonzero value while idle starts a transfer, and status (select 5, bit 0) reads 1 until the transfer completes. Writing zero starts nothing.
- R3: The format code is the control register (select 2) bits [1:0]. Code 00 moves 24-bit program words using three bytes, with program-memory select high. Code 01 moves 16-bit data words using two bytes. Code 10 moves one byte into data bits [15:8]. Code 11 moves one byte into data bits [7:0]. All unused bits of a loaded word are zero.
- R4: The bytes of a word move most significant first at consecutive external addresses. A store in code 10 or 11 writes the byte taken from data bits [15:8] or [7:0] respectively.
- R5: Control bit 2 selects the direction. 0 loads from byte memory into on-chip memory with no external write. 1 stores on-chip words to byte memory with no on-chip write.
- R6: The external address is 22 bits wide: the page in control bits [15:8] above the 14-bit offset (select 1). It advances by one per byte, carries from offset into page, and wraps at 22 bits. Page and offset read back as the next address.
- R7: Each byte strobe is held for wait+1 cycles, where wait is the value of select 4. Read and write strobes are never both active.
- R8: Each word makes exactly one on-chip request. The request is held with a stable address and data until granted. The on-chip address (select 0) advances by one per word and wraps at 14 bits.
- R9: The count decrements once per word and reads back zero at the end.
- R10: When the last word completes, busy falls and the interrupt is high for exactly one cycle, once per transfer.
- R11: Register writes made while busy are ignored, including writes to page and offset.
- R12: The halt output equals control bit 3 while busy and is low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 iaddr, 1 offset, 2 control, 3 count, 4 wait, 5 status) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_sel |
| bm_addr | output | 22 | External byte address {page, offset} |
| bm_rd | output | 1 | External read strobe |
| bm_wr | output | 1 | External write strobe |
| bm_wdata | output | 8 | External write byte |
| bm_rdata | input | 8 | External read byte, sampled on the last strobe cycle |
| im_req | output | 1 | On-chip memory request |
| im_we | output | 1 | On-chip write (1) or read (0) |
| im_pm | output | 1 | Selects program memory (1) or data memory (0) |
| im_addr | output | 14 | On-chip word address |
| im_wdata | output | 24 | On-chip write word |
| im_rdata | input | 24 | On-chip read word, valid in the grant cycle |
| im_gnt | input | 1 | On-chip grant |
| cpu_halt | output | 1 | Processor halt request |
| irq_done | output | 1 | Completion interrupt pulse |

## Verification
The hardest situation to reach is a multi-byte word whose bytes straddle a page carry, or the 22-bit wrap, while an on-chip grant is held back. In that situation, address advance, byte order and the request hold all interact. The stimulus places the start offset one to four bytes below the end of a page, and once at page 255 offset 3FFF. It sweeps all formats, both directions, several wait counts and grant delays of zero to two cycles. Expected bytes and words come from address-derived patterns. Writes issued in the middle of a transfer show up only as a wrong final address or count, so they are checked through readback after completion.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    localparam int PAGE_W = 8;
    localparam int OFF_W  = 14;
    localparam int EXT_W  = PAGE_W + OFF_W;
    localparam int WORD_W = 24;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 16;

    typedef enum logic [1:0] {
        FMT_PM24  = 2'b00,
        FMT_DM16  = 2'b01,
        FMT_DM8HI = 2'b10,
        FMT_DM8LO = 2'b11
    } fmt_e;

    typedef enum logic [2:0] {
        SEL_IADDR  = 3'd0,
        SEL_OFFSET = 3'd1,
        SEL_CTRL   = 3'd2,
        SEL_COUNT  = 3'd3,
        SEL_WAIT   = 3'd4,
        SEL_STATUS = 3'd5
    } sel_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_BYTE  = 3'd2,
        S_PUT   = 3'd3,
        S_STEP  = 3'd4
    } state_e;

    function automatic logic [1:0] bytes_per_word(input fmt_e f);
        unique case (f)
            FMT_PM24: return 2'd3;
            FMT_DM16: return 2'd2;
            default:  return 2'd1;
        endcase
    endfunction
endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int IADDR_W = 14,
    parameter int CNT_W   = 14,
    parameter int WAIT_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [2:0]          reg_sel,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                busy,
    input  logic                byte_done,
    input  logic                word_done,
    output logic                start,
    output logic [IADDR_W-1:0]  iaddr,
    output logic [EXT_W-1:0]    ext_addr,
    output fmt_e                fmt,
    output logic                dir,
    output logic                halt_en,
    output logic [CNT_W-1:0]    count,
    output logic [WAIT_W-1:0]   wait_cnt
);
    logic wr_ok;

    assign wr_ok = reg_wr && !busy;
    assign start = wr_ok && (reg_sel == SEL_COUNT) && (reg_wdata[CNT_W-1:0] != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iaddr    <= '0;
            ext_addr <= '0;
            fmt      <= FMT_PM24;
            dir      <= 1'b0;
            halt_en  <= 1'b0;
            count    <= '0;
            wait_cnt <= '0;
        end else if (wr_ok) begin
            unique case (reg_sel)
                SEL_IADDR:  iaddr <= reg_wdata[IADDR_W-1:0];
                SEL_OFFSET: ext_addr[OFF_W-1:0] <= reg_wdata[OFF_W-1:0];
                SEL_CTRL: begin
                    ext_addr[EXT_W-1:OFF_W] <= reg_wdata[REG_W-1:REG_W-PAGE_W];
                    halt_en <= reg_wdata[3];
                    dir     <= reg_wdata[2];
                    fmt     <= fmt_e'(reg_wdata[1:0]);
                end
                SEL_COUNT:  count    <= reg_wdata[CNT_W-1:0];
                SEL_WAIT:   wait_cnt <= reg_wdata[WAIT_W-1:0];
                default: ;
            endcase
        end else begin
            if (byte_done) ext_addr <= ext_addr + EXT_W'(1);
            if (word_done) begin
                iaddr <= iaddr + IADDR_W'(1);
                count <= count - CNT_W'(1);
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_IADDR:  reg_rdata = REG_W'(iaddr);
            SEL_OFFSET: reg_rdata = REG_W'(ext_addr[OFF_W-1:0]);
            SEL_CTRL:   reg_rdata = {ext_addr[EXT_W-1:OFF_W], 4'b0000, halt_en, dir, fmt};
            SEL_COUNT:  reg_rdata = REG_W'(count);
            SEL_WAIT:   reg_rdata = REG_W'(wait_cnt);
            SEL_STATUS: reg_rdata = REG_W'(busy);
            default:    reg_rdata = '0;
        endcase
    end

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && (count != $past(count))) |-> (count == $past(count) - CNT_W'(1)));

    // R11
    locked_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$past(byte_done)) |-> $stable(ext_addr));
endmodule

// File: rtl/bmdma_pack.sv
module bmdma_pack
    import bmdma_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  fmt_e               fmt,
    input  logic [1:0]         byte_idx,
    input  logic               load_byte,
    input  logic [BYTE_W-1:0]  bm_rdata,
    input  logic               cap_word,
    input  logic [WORD_W-1:0]  im_rdata,
    output logic [WORD_W-1:0]  asm_word,
    output logic [BYTE_W-1:0]  out_byte
);
    logic [WORD_W-1:0] hold;
    logic [1:0]        pos;

    always_ff @(posedge clk) begin
        if (!rst_n)         hold <= '0;
        else if (cap_word)  hold <= im_rdata;
        else if (load_byte) hold <= {hold[WORD_W-BYTE_W-1:0], bm_rdata};
    end

    always_comb begin
        unique case (fmt)
            FMT_PM24:  asm_word = hold;
            FMT_DM16:  asm_word = {8'h00, hold[15:0]};
            FMT_DM8HI: asm_word = {8'h00, hold[7:0], 8'h00};
            default:   asm_word = {16'h0000, hold[7:0]};
        endcase
    end

    always_comb begin
        unique case (fmt)
            FMT_PM24:  pos = 2'd2 - byte_idx;
            FMT_DM16:  pos = 2'd1 - byte_idx;
            FMT_DM8HI: pos = 2'd1;
            default:   pos = 2'd0;
        endcase
        out_byte = hold[{pos, 3'b000} +: BYTE_W];
    end
endmodule

// File: rtl/bmdma_seq.sv
module bmdma_seq
    import bmdma_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  fmt_e              fmt,
    input  logic              dir,
    input  logic [CNT_W-1:0]  count,
    input  logic [WAIT_W-1:0] wait_cnt,
    input  logic              im_gnt,
    output logic              busy,
    output logic              bm_rd,
    output logic              bm_wr,
    output logic              im_req,
    output logic              im_we,
    output logic              byte_done,
    output logic              word_done,
    output logic              load_byte,
    output logic              cap_word,
    output logic [1:0]        byte_idx,
    output logic              irq
);
    state_e            state, state_nx;
    logic [WAIT_W-1:0] wcnt;
    logic [1:0]        nbytes;
    logic              last_cycle, last_byte, last_word;

    assign nbytes     = bytes_per_word(fmt);
    assign last_cycle = (state == S_BYTE) && (wcnt == wait_cnt);
    assign last_byte  = (byte_idx == nbytes - 2'd1);
    assign last_word  = (count == CNT_W'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = dir ? S_FETCH : S_BYTE;
            S_FETCH: if (im_gnt) state_nx = S_BYTE;
            S_BYTE:  if (last_cycle && last_byte) state_nx = dir ? S_STEP : S_PUT;
            S_PUT:   if (im_gnt) state_nx = S_STEP;
            S_STEP:  state_nx = last_word ? S_IDLE : (dir ? S_FETCH : S_BYTE);
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            wcnt     <= '0;
            byte_idx <= 2'd0;
            irq      <= 1'b0;
        end else begin
            state <= state_nx;
            irq   <= (state == S_STEP) && last_word;
            if (state != S_BYTE || last_cycle) wcnt <= '0;
            else                               wcnt <= wcnt + WAIT_W'(1);
            if (state == S_IDLE || state == S_STEP) byte_idx <= 2'd0;
            else if (last_cycle && !last_byte)      byte_idx <= byte_idx + 2'd1;
        end
    end

    always_comb begin
        busy      = (state != S_IDLE);
        bm_rd     = (state == S_BYTE) && !dir;
        bm_wr     = (state == S_BYTE) && dir;
        im_req    = (state == S_FETCH) || (state == S_PUT);
        im_we     = (state == S_PUT);
        byte_done = last_cycle;
        load_byte = last_cycle && !dir;
        cap_word  = (state == S_FETCH) && im_gnt;
        word_done = (state == S_STEP);
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (im_req && !im_gnt) |=> im_req);

    // R10
    done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4
    byte_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BYTE) |-> (byte_idx < nbytes));
endmodule

// File: rtl/bytemem_dma.sv
module bytemem_dma
    import bmdma_pkg::*;
#(
    parameter int IADDR_W = 14,
    parameter int CNT_W   = 14,
    parameter int WAIT_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [2:0]          reg_sel,
    input  logic [15:0]         reg_wdata,
    output logic [15:0]         reg_rdata,
    output logic [21:0]         bm_addr,
    output logic                bm_rd,
    output logic                bm_wr,
    output logic [7:0]          bm_wdata,
    input  logic [7:0]          bm_rdata,
    output logic                im_req,
    output logic                im_we,
    output logic                im_pm,
    output logic [IADDR_W-1:0]  im_addr,
    output logic [23:0]         im_wdata,
    input  logic [23:0]         im_rdata,
    input  logic                im_gnt,
    output logic                cpu_halt,
    output logic                irq_done
);
    logic              busy, start, byte_done, word_done, load_byte, cap_word;
    logic              dir, halt_en;
    fmt_e              fmt;
    logic [1:0]        byte_idx;
    logic [CNT_W-1:0]  count;
    logic [WAIT_W-1:0] wait_cnt;
    logic [EXT_W-1:0]  ext_addr;

    bmdma_regs #(.IADDR_W(IADDR_W), .CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .byte_done(byte_done), .word_done(word_done), .start(start),
        .iaddr(im_addr), .ext_addr(ext_addr), .fmt(fmt), .dir(dir),
        .halt_en(halt_en), .count(count), .wait_cnt(wait_cnt)
    );

    bmdma_seq #(.CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt), .dir(dir),
        .count(count), .wait_cnt(wait_cnt), .im_gnt(im_gnt), .busy(busy),
        .bm_rd(bm_rd), .bm_wr(bm_wr), .im_req(im_req), .im_we(im_we),
        .byte_done(byte_done), .word_done(word_done), .load_byte(load_byte),
        .cap_word(cap_word), .byte_idx(byte_idx), .irq(irq_done)
    );

    bmdma_pack u_pack (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .byte_idx(byte_idx),
        .load_byte(load_byte), .bm_rdata(bm_rdata), .cap_word(cap_word),
        .im_rdata(im_rdata), .asm_word(im_wdata), .out_byte(bm_wdata)
    );

    assign bm_addr  = ext_addr;
    assign im_pm    = (fmt == FMT_PM24);
    assign cpu_halt = busy && halt_en;

    // R8
    im_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (im_req && !im_gnt) |=> ($stable(im_addr) && $stable(im_wdata)));

    // R6
    bm_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bm_rd || bm_wr) && $past(bm_rd || bm_wr) && !$past(byte_done)) |-> $stable(bm_addr));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bm_rd && bm_wr));
endmodule

// File: tb/test_bytemem_dma.sv
`timescale 1ns/1ps
module test_bytemem_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [21:0] bm_addr;
    logic        bm_rd, bm_wr;
    logic [7:0]  bm_wdata, bm_rdata;
    logic        im_req, im_we, im_pm;
    logic [13:0] im_addr;
    logic [23:0] im_wdata, im_rdata;
    logic        im_gnt = 1'b0;
    logic        cpu_halt, irq_done;

    int n_chk = 0, n_fail = 0;
    int glat = 0, gcnt = 0;
    int irq_cnt = 0, irq_wide = 0, strobe_cyc = 0, ext_wr_cyc = 0, overlap = 0, iw_n = 0;
    logic irq_prev = 1'b0;
    bit   reported = 0;
    logic [7:0]  ext_st [int];
    logic [23:0] iw_val [int];
    logic        iw_pm  [int];

    always #2 clk = ~clk;

    bytemem_dma i_bytemem_dma (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bm_addr(bm_addr),
        .bm_rd(bm_rd), .bm_wr(bm_wr), .bm_wdata(bm_wdata), .bm_rdata(bm_rdata),
        .im_req(im_req), .im_we(im_we), .im_pm(im_pm), .im_addr(im_addr),
        .im_wdata(im_wdata), .im_rdata(im_rdata), .im_gnt(im_gnt),
        .cpu_halt(cpu_halt), .irq_done(irq_done)
    );

    function automatic logic [7:0] ext_pat(input logic [21:0] a);
        return a[7:0] ^ a[15:8] ^ {a[21:16], 2'b01};
    endfunction

    function automatic logic [23:0] int_pat(input logic pm, input logic [13:0] a);
        if (pm) return {a[7:0] + 8'h11, a[10:3] ^ 8'h5C, a[7:0] ^ 8'hE7};
        return {8'h00, a[7:0] ^ 8'h3A, a[7:0] + 8'h71};
    endfunction

    always_comb bm_rdata = bm_rd ? ext_pat(bm_addr) : 8'h00;
    always_comb im_rdata = int_pat(im_pm, im_addr);

    always @(negedge clk) begin
        if (bm_rd || bm_wr) strobe_cyc++;
        if (bm_rd && bm_wr) overlap++;
        if (bm_wr) begin
            ext_wr_cyc++;
            ext_st[int'(bm_addr)] = bm_wdata;
        end
        if (irq_done) begin
            irq_cnt++;
            if (irq_prev) irq_wide++;
        end
        irq_prev = irq_done;
        if (im_req) begin
            if (gcnt >= glat) begin
                im_gnt = 1'b1;
                if (im_we) begin
                    iw_n++;
                    iw_val[int'(im_addr)] = im_wdata;
                    iw_pm[int'(im_addr)]  = im_pm;
                end
            end else begin
                im_gnt = 1'b0;
            end
            gcnt++;
        end else begin
            im_gnt = 1'b0;
            gcnt = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        end
        $finish;
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] s, output logic [15:0] r);
        @(negedge clk);
        reg_sel = s;
        #1 r = reg_rdata;
    endtask

    task automatic run(input int f, input int d, input int h, input int w, input int gl,
                       input logic [7:0] pg, input logic [13:0] off, input logic [13:0] ia,
                       input int n);
        int nb;
        logic [21:0] e0, ea;
        logic [15:0] r;
        logic [23:0] wexp, wsrc;
        logic [7:0]  b0, b1, b2, bexp;
        logic [13:0] ik;
        nb = (f == 0) ? 3 : (f == 1) ? 2 : 1;
        e0 = {pg, off};
        wr_reg(3'd0, 16'(ia));
        wr_reg(3'd1, 16'(off));
        wr_reg(3'd2, {pg, 4'h0, 1'(h), 1'(d), 2'(f)});
        wr_reg(3'd4, 16'(w));
        glat = gl;
        irq_cnt = 0; irq_wide = 0; strobe_cyc = 0; ext_wr_cyc = 0; overlap = 0; iw_n = 0;
        ext_st.delete(); iw_val.delete(); iw_pm.delete();
        wr_reg(3'd3, 16'(n));
        #1 chk("R12 halt while busy", 32'(cpu_halt), 32'(h));
        rd_reg(3'd5, r);
        chk("R2 busy after start", 32'(r), 32'd1);
        if (n >= 3) begin
            wr_reg(3'd1, 16'h1234);
            wr_reg(3'd2, 16'hA50F ^ {14'h0, 2'(f)});
            wr_reg(3'd3, 16'h0005);
            wr_reg(3'd0, 16'h0777);
        end
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            #1;
            if (irq_cnt != 0) break;
        end
        repeat (3) @(negedge clk);
        chk("R10 one interrupt", 32'(irq_cnt), 32'd1);
        chk("R10 one-cycle pulse", 32'(irq_wide), 32'd0);
        chk("R12 halt low when idle", 32'(cpu_halt), 32'd0);
        rd_reg(3'd5, r); chk("R10 busy cleared", 32'(r), 32'd0);
        rd_reg(3'd3, r); chk("R9 count zero", 32'(r), 32'd0);
        rd_reg(3'd0, r); chk("R8 iaddr advance", 32'(r), 32'(14'(ia + 14'(n))));
        ea = e0 + 22'(n * nb);
        rd_reg(3'd1, r); chk("R6 R11 offset final", 32'(r), 32'(ea[13:0]));
        rd_reg(3'd2, r); chk("R6 R11 page and control", 32'(r), 32'({ea[21:14], 4'h0, 1'(h), 1'(d), 2'(f)}));
        chk("R7 strobe cycles", 32'(strobe_cyc), 32'(n * nb * (w + 1)));
        chk("R7 no strobe overlap", 32'(overlap), 32'd0);
        if (d == 0) begin
            chk("R5 no external write on load", 32'(ext_wr_cyc), 32'd0);
            chk("R8 one request per word", 32'(iw_n), 32'(n));
            for (int k = 0; k < n; k++) begin
                ik = ia + 14'(k);
                b0 = ext_pat(e0 + 22'(k * nb));
                b1 = ext_pat(e0 + 22'(k * nb + 1));
                b2 = ext_pat(e0 + 22'(k * nb + 2));
                unique case (f)
                    0: wexp = {b0, b1, b2};
                    1: wexp = {8'h00, b0, b1};
                    2: wexp = {8'h00, b0, 8'h00};
                    default: wexp = {16'h0000, b0};
                endcase
                if (iw_val.exists(int'(ik))) begin
                    chk("R3 R4 loaded word", 32'(iw_val[int'(ik)]), 32'(wexp));
                    chk("R3 memory select", 32'(iw_pm[int'(ik)]), 32'(f == 0));
                end else begin
                    chk("R8 word written", 32'd0, 32'd1);
                end
            end
        end else begin
            chk("R5 no on-chip write on store", 32'(iw_n), 32'd0);
            for (int k = 0; k < n; k++) begin
                wsrc = int_pat(f == 0, ia + 14'(k));
                for (int j = 0; j < nb; j++) begin
                    unique case (f)
                        0: bexp = (j == 0) ? wsrc[23:16] : (j == 1) ? wsrc[15:8] : wsrc[7:0];
                        1: bexp = (j == 0) ? wsrc[15:8] : wsrc[7:0];
                        2: bexp = wsrc[15:8];
                        default: bexp = wsrc[7:0];
                    endcase
                    ea = e0 + 22'(k * nb + j);
                    if (ext_st.exists(int'(ea)))
                        chk("R4 R6 stored byte", 32'(ext_st[int'(ea)]), 32'(bexp));
                    else
                        chk("R4 R6 byte present", 32'd0, 32'd1);
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [15:0] r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int s = 0; s < 6; s++) begin
            rd_reg(3'(s), r);
            chk("R1 register reset", 32'(r), 32'd0);
        end
        chk("R1 idle outputs", 32'({bm_rd, bm_wr, im_req, cpu_halt, irq_done}), 32'd0);
        // R2 zero count does not start
        wr_reg(3'd3, 16'h0000);
        strobe_cyc = 0;
        repeat (8) @(negedge clk);
        rd_reg(3'd5, r);
        chk("R2 zero count stays idle", 32'(r), 32'd0);
        chk("R2 zero count no strobe", 32'(strobe_cyc), 32'd0);
        for (int f = 0; f < 4; f++)
            for (int d = 0; d < 2; d++)
                for (int wi = 0; wi < 3; wi++) begin
                    int w;
                    w = (wi == 2) ? 3 : wi;
                    run(f, d, d, w, (f + w) % 3, 8'(f * 16 + d * 4 + w), 14'h3FFE - 14'(f), 14'h3FFD, 4);
                end
        run(0, 0, 1, 2, 1, 8'hFF, 14'h3FFF, 14'h0010, 3);
        run(0, 1, 0, 1, 2, 8'hFF, 14'h3FFE, 14'h0020, 3);
        run(3, 0, 0, 3, 0, 8'h01, 14'h0000, 14'h0100, 1);
        run(1, 1, 1, 7, 2, 8'h7F, 14'h3FFF, 14'h3FFF, 5);
        report();
    end
endmodule